// File: doc/BRIEF.md
# Four-Stage Watchdog Timer with Key Lock

The block is a watchdog that walks through four timeout stages in a fixed ring. Each stage owns a timeout, counted in prescaled ticks, and an action taken when that timeout runs out. The action can be nothing, a sticky interrupt request, or a one-cycle pulse on one of three reset outputs. The reset outputs are a CPU reset, a main system reset and a full reset that also covers the always-on domain. The reset logic itself lives outside the block. Software keeps the block quiet by writing the feed register, which sends the ring back to its first stage and zeroes the tick counter.

Every write to configuration goes through a simple one-cycle write port and is refused unless the block has been unlocked. Unlocking means writing a parameter-defined 32-bit key to the key register, and writing zero to that register locks the block again. Reads are combinational from a separate read address. A status word shows the pending interrupt, the lock state and the current stage.

Top module: `stage_watchdog`

## Requirements
- R1: After reset the block is stopped and locked, all four actions read as 0, the prescaler reads 1, the status word reads 0 and the irq, cpu_rst, sys_rst and full_rst outputs are low.
- R2: While locked, writes to the control word (address 0), the timeouts (addresses 1 to 4), the prescaler (address 5) and the feed register (address 6) change nothing that can be read back or observed.
- R3: Writing UNLOCK_KEY to address 9 unlocks the block, writing 0 there locks it, and any other value leaves the lock as it was. This register accepts writes in either state and is reflected in status bit 1 (address 10).
- R4: One tick occurs every P clock cycles, where P is the 16-bit prescaler value at address 5. A value of 0 acts as 1.
- R5: A stage with timeout T ends on its T-th tick: the counter clears and the stage (status bits 3:2) moves to the next one, and from stage 3 it goes back to stage 0. A stage whose action is off still spends its full timeout.
- R6: The 3-bit action of stage i sits in control bits 2+3i to 4+3i. Code 2 gives a one-cycle cpu_rst pulse, code 3 a one-cycle sys_rst pulse and code 4 a one-cycle full_rst pulse, each starting in the cycle that follows the ending tick.
- R7: When FULL_RST_EN is 0, code 4 behaves as off. Codes 0, 5, 6 and 7 never cause an action.
- R8: An accepted write to the feed register returns the block to stage 0 with the tick counter and the prescaler count cleared, so the next stage-0 expiry comes a full stage-0 timeout later.
- R9: Control bit 0 starts counting and reads back as written. Clearing it stops counting, puts the block in stage 0 and stops all reset pulses.
- R10: Code 1 sets a sticky pending bit (status bit 0). irq is high while that bit is set, control bit 1 (level enable) is set and bit 0 at address 7 (interrupt enable) is set. Writing 1 to bit 0 at address 8 clears the pending bit. Addresses 7 and 8 accept writes even while locked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, combinational from rd_addr |
| irq | output | 1 | Level interrupt request |
| cpu_rst | output | 1 | One-cycle CPU reset request |
| sys_rst | output | 1 | One-cycle main system reset request |
| full_rst | output | 1 | One-cycle full reset request |

## Verification
The bench goes after the exact cycle of every expiry across a whole lap of the ring and into the wrap from stage 3 to stage 0. An off-by-one in the tick comparison or the prescaler would move each pulse by P cycles, and a wrong wrap would drop or misplace the second lap. It checks that a feed restarts stage 0 from zero while a locked feed is ignored and the ring keeps moving. A design that leaked writes past the lock would show a changed stage or a changed register. It runs a second copy with FULL_RST_EN cleared, where code 4 must still spend its time but produce no pulse. It also checks that a pending interrupt only raises irq once both enables are set and that it drops on the clear write.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int NUM_STAGES = 4;
   localparam int STG_W      = 2;
   localparam int ACT_W      = 3;
   localparam int ACT_LSB    = 2;

   typedef enum logic [ACT_W-1:0] {
      ACT_OFF  = 3'd0,
      ACT_IRQ  = 3'd1,
      ACT_CPU  = 3'd2,
      ACT_SYS  = 3'd3,
      ACT_FULL = 3'd4
   } wdg_act_e;

   localparam int ADR_CTRL   = 0;
   localparam int ADR_TMO0   = 1;
   localparam int ADR_PRE    = 5;
   localparam int ADR_FEED   = 6;
   localparam int ADR_INTEN  = 7;
   localparam int ADR_INTCLR = 8;
   localparam int ADR_KEY    = 9;
   localparam int ADR_STAT   = 10;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 4,
   parameter int                TMO_W      = 32,
   parameter int                PRE_W      = 16,
   parameter int                TMO_RST    = 1000,
   parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h5AC3_E17B
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                wr_en,
   input  logic [ADDR_W-1:0]                   wr_addr,
   input  logic [DATA_W-1:0]                   wr_data,
   input  logic [ADDR_W-1:0]                   rd_addr,
   input  logic                                pending,
   input  logic [STG_W-1:0]                    stage,
   output logic [DATA_W-1:0]                   rd_data,
   output logic                                run,
   output logic                                lvl_en,
   output logic                                int_en,
   output logic                                unlocked,
   output logic [NUM_STAGES-1:0][ACT_W-1:0]    acts,
   output logic [NUM_STAGES-1:0][TMO_W-1:0]    tmo,
   output logic [PRE_W-1:0]                    prescale,
   output logic                                feed,
   output logic                                int_clr
);
   localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(ADR_CTRL);
   localparam logic [ADDR_W-1:0] A_TMO0   = ADDR_W'(ADR_TMO0);
   localparam logic [ADDR_W-1:0] A_PRE    = ADDR_W'(ADR_PRE);
   localparam logic [ADDR_W-1:0] A_FEED   = ADDR_W'(ADR_FEED);
   localparam logic [ADDR_W-1:0] A_INTEN  = ADDR_W'(ADR_INTEN);
   localparam logic [ADDR_W-1:0] A_INTCLR = ADDR_W'(ADR_INTCLR);
   localparam logic [ADDR_W-1:0] A_KEY    = ADDR_W'(ADR_KEY);
   localparam logic [ADDR_W-1:0] A_STAT   = ADDR_W'(ADR_STAT);

   logic wr_ok;
   assign wr_ok = wr_en && unlocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run      <= 1'b0;
         lvl_en   <= 1'b0;
         int_en   <= 1'b0;
         unlocked <= 1'b0;
         acts     <= '0;
         prescale <= PRE_W'(1);
         for (int i = 0; i < NUM_STAGES; i++) tmo[i] <= TMO_W'(TMO_RST);
      end else begin
         if (wr_ok && wr_addr == A_CTRL) begin
            run    <= wr_data[0];
            lvl_en <= wr_data[1];
            for (int i = 0; i < NUM_STAGES; i++)
               acts[i] <= wr_data[ACT_LSB + ACT_W*i +: ACT_W];
         end
         for (int i = 0; i < NUM_STAGES; i++)
            if (wr_ok && wr_addr == A_TMO0 + ADDR_W'(i))
               tmo[i] <= wr_data[TMO_W-1:0];
         if (wr_ok && wr_addr == A_PRE)
            prescale <= wr_data[PRE_W-1:0];
         if (wr_en && wr_addr == A_INTEN)
            int_en <= wr_data[0];
         if (wr_en && wr_addr == A_KEY) begin
            if (wr_data == UNLOCK_KEY)  unlocked <= 1'b1;
            else if (wr_data == '0)     unlocked <= 1'b0;
         end
      end
   end

   assign feed    = wr_ok && wr_addr == A_FEED;
   assign int_clr = wr_en && wr_addr == A_INTCLR && wr_data[0];

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL) begin
         rd_data[0] = run;
         rd_data[1] = lvl_en;
         for (int i = 0; i < NUM_STAGES; i++)
            rd_data[ACT_LSB + ACT_W*i +: ACT_W] = acts[i];
      end
      for (int i = 0; i < NUM_STAGES; i++)
         if (rd_addr == A_TMO0 + ADDR_W'(i))
            rd_data[TMO_W-1:0] = tmo[i];
      if (rd_addr == A_PRE)   rd_data[PRE_W-1:0] = prescale;
      if (rd_addr == A_INTEN) rd_data[0] = int_en;
      if (rd_addr == A_STAT) begin
         rd_data[0]       = pending;
         rd_data[1]       = unlocked;
         rd_data[3:2]     = stage;
      end
   end
endmodule

// File: rtl/wdg_tick.sv
module wdg_tick #(
   parameter int PRE_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic [PRE_W-1:0] prescale,
   output logic             tick
);
   logic [PRE_W-1:0] pcnt;
   logic [PRE_W-1:0] last;

   assign last = (prescale == '0) ? '0 : prescale - PRE_W'(1);
   assign tick = run && (pcnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pcnt <= '0;
      else if (!run || restart)    pcnt <= '0;
      else if (tick)               pcnt <= '0;
      else                         pcnt <= pcnt + PRE_W'(1);
   end
endmodule

// File: rtl/wdg_stages.sv
module wdg_stages
   import wdg_pkg::*;
#(
   parameter int TMO_W       = 32,
   parameter bit FULL_RST_EN = 1'b1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             run,
   input  logic                             feed,
   input  logic                             tick,
   input  logic                             int_clr,
   input  logic [NUM_STAGES-1:0][TMO_W-1:0] tmo,
   input  logic [NUM_STAGES-1:0][ACT_W-1:0] acts,
   output logic [STG_W-1:0]                 stage,
   output logic                             pending,
   output logic                             cpu_rst,
   output logic                             sys_rst,
   output logic                             full_rst
);
   logic [TMO_W-1:0] cnt;
   logic [TMO_W:0]   cnt_nxt;
   logic [ACT_W-1:0] act_cur;
   logic             expire;
   logic             fire;
   logic             full_hit;

   assign act_cur = acts[stage];
   assign cnt_nxt = {1'b0, cnt} + {{TMO_W{1'b0}}, 1'b1};
   assign expire  = tick && (cnt_nxt >= {1'b0, tmo[stage]});
   assign fire    = expire && !feed;

   generate
      if (FULL_RST_EN) begin : g_full
         assign full_hit = (act_cur == ACT_FULL);
      end else begin : g_nofull
         assign full_hit = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         stage <= '0;
      end else if (!run || feed) begin
         cnt   <= '0;
         stage <= '0;
      end else if (expire) begin
         cnt   <= '0;
         stage <= stage + STG_W'(1);
      end else if (tick) begin
         cnt   <= cnt_nxt[TMO_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cpu_rst  <= 1'b0;
         sys_rst  <= 1'b0;
         full_rst <= 1'b0;
         pending  <= 1'b0;
      end else begin
         cpu_rst  <= fire && (act_cur == ACT_CPU);
         sys_rst  <= fire && (act_cur == ACT_SYS);
         full_rst <= fire && full_hit;
         if (fire && act_cur == ACT_IRQ) pending <= 1'b1;
         else if (int_clr)               pending <= 1'b0;
      end
   end
endmodule

// File: rtl/stage_watchdog.sv
module stage_watchdog
   import wdg_pkg::*;
#(
   parameter int                DATA_W      = 32,
   parameter int                ADDR_W      = 4,
   parameter int                TMO_W       = 32,
   parameter int                PRE_W       = 16,
   parameter int                TMO_RST     = 1000,
   parameter bit                FULL_RST_EN = 1'b1,
   parameter logic [DATA_W-1:0] UNLOCK_KEY  = 32'h5AC3_E17B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq,
   output logic              cpu_rst,
   output logic              sys_rst,
   output logic              full_rst
);
   localparam int CTRL_BITS = ACT_LSB + ACT_W*NUM_STAGES;

   if (DATA_W < CTRL_BITS || DATA_W < 32) begin : g_bad_data
      $error("stage_watchdog: DATA_W too narrow for control word and key");
   end
   if (TMO_W < 1 || TMO_W > DATA_W) begin : g_bad_tmo
      $error("stage_watchdog: TMO_W must lie in 1..DATA_W");
   end
   if (PRE_W < 1 || PRE_W > DATA_W) begin : g_bad_pre
      $error("stage_watchdog: PRE_W must lie in 1..DATA_W");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("stage_watchdog: ADDR_W must be at least 4");
   end

   logic                             run_w, lvl_w, inten_w, unl_w;
   logic                             feed_w, clr_w, tick_w, pend_w;
   logic [STG_W-1:0]                 stage_w;
   logic [NUM_STAGES-1:0][ACT_W-1:0] acts_w;
   logic [NUM_STAGES-1:0][TMO_W-1:0] tmo_w;
   logic [PRE_W-1:0]                 pre_w;

   wdg_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TMO_W(TMO_W), .PRE_W(PRE_W),
      .TMO_RST(TMO_RST), .UNLOCK_KEY(UNLOCK_KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .pending(pend_w),
      .stage(stage_w), .rd_data(rd_data), .run(run_w), .lvl_en(lvl_w),
      .int_en(inten_w), .unlocked(unl_w), .acts(acts_w), .tmo(tmo_w),
      .prescale(pre_w), .feed(feed_w), .int_clr(clr_w)
   );

   wdg_tick #(.PRE_W(PRE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run_w), .restart(feed_w),
      .prescale(pre_w), .tick(tick_w)
   );

   wdg_stages #(.TMO_W(TMO_W), .FULL_RST_EN(FULL_RST_EN)) u_stages (
      .clk(clk), .rst_n(rst_n), .run(run_w), .feed(feed_w),
      .tick(tick_w), .int_clr(clr_w), .tmo(tmo_w), .acts(acts_w),
      .stage(stage_w), .pending(pend_w), .cpu_rst(cpu_rst),
      .sys_rst(sys_rst), .full_rst(full_rst)
   );

   assign irq = pend_w && lvl_w && inten_w;
endmodule

// File: rtl/wdg_chk.sv
module wdg_chk
   import wdg_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int PRE_W       = 16,
   parameter bit FULL_RST_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              unlocked,
   input logic              run,
   input logic [PRE_W-1:0]  prescale,
   input logic [STG_W-1:0]  stage,
   input logic              pending,
   input logic              cpu_rst,
   input logic              sys_rst,
   input logic              full_rst
);
   logic feed_wr, clr_wr;
   assign feed_wr = wr_en && wr_addr == ADDR_W'(ADR_FEED);
   assign clr_wr  = wr_en && wr_addr == ADDR_W'(ADR_INTCLR) && wr_data[0];

   a_r2_locked_run: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(run));
   a_r2_locked_prescale: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(prescale));
   a_r5_stage_steps: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stage == $past(stage) || stage == $past(stage) + 2'd1 || stage == '0));
   a_r6_one_reset_kind: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cpu_rst, sys_rst, full_rst}));
   a_r8_feed_to_stage0: assert property (@(posedge clk) disable iff (!rst_n)
      (feed_wr && unlocked) |=> stage == '0);
   a_r9_stopped_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!cpu_rst && !sys_rst && !full_rst && stage == '0));
   a_r10_pending_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !clr_wr) |=> pending);

   if (!FULL_RST_EN) begin : g_nofull_chk
      a_r7_no_full_pulse: assert property (@(posedge clk) disable iff (!rst_n)
         !full_rst);
   end
endmodule

bind stage_watchdog wdg_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_W(PRE_W), .FULL_RST_EN(FULL_RST_EN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .unlocked(unl_w), .run(run_w), .prescale(pre_w),
   .stage(stage_w), .pending(pend_w), .cpu_rst(cpu_rst),
   .sys_rst(sys_rst), .full_rst(full_rst)
);

// File: tb/stage_watchdog_test.sv
module stage_watchdog_test;
   localparam logic [31:0] KEY = 32'h5AC3_E17B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data, rd_data_nf;
   logic        irq, cpu_rst, sys_rst, full_rst;
   logic        irq_nf, cpu_nf, sys_nf, full_nf;

   always #4 clk = ~clk;

   stage_watchdog #(.UNLOCK_KEY(KEY)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
      .cpu_rst(cpu_rst), .sys_rst(sys_rst), .full_rst(full_rst));

   stage_watchdog #(.UNLOCK_KEY(KEY), .FULL_RST_EN(1'b0)) uut_nofull (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data_nf), .irq(irq_nf),
      .cpu_rst(cpu_nf), .sys_rst(sys_nf), .full_rst(full_nf));

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int errors = 0;
   int checks = 0;
   int wr_last = 0;
   int nf_cpu = 0, nf_full = 0;

   typedef struct { int kind; int at; } ev_t;
   ev_t expq[$];

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic expect_ev(int kind, int at);
      expq.push_back('{kind, at});
   endtask

   // kinds: 0 irq rise, 1 cpu_rst, 2 sys_rst, 3 full_rst
   task automatic seen(int kind);
      ev_t e;
      checks++;
      if (expq.size() == 0) begin
         errors++;
         $display("FAIL R5 R6 event: actual kind=%0d cycle=%0d expected none", kind, cyc);
      end else begin
         e = expq.pop_front();
         if (e.kind != kind || e.at != cyc) begin
            errors++;
            $display("FAIL R5 R6 event: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                     kind, cyc, e.kind, e.at);
         end
      end
   endtask

   logic irq_prev = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (irq && !irq_prev) seen(0);
         if (cpu_rst)          seen(1);
         if (sys_rst)          seen(2);
         if (full_rst)         seen(3);
         if (cpu_nf)           nf_cpu++;
         if (full_nf)          nf_full++;
      end
      irq_prev = irq;
   end

   task automatic bus_wr(int addr, logic [31:0] data);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = 4'(addr);
      wr_data = data;
      @(posedge clk);
      #1;
      wr_last = cyc;
      wr_en   = 1'b0;
   endtask

   task automatic rd(int addr, output logic [31:0] v);
      @(negedge clk);
      rd_addr = 4'(addr);
      #1;
      v = rd_data;
   endtask

   task automatic wait_until(int c);
      while (cyc < c) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R5 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n, f, w;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(0, v);  chk("R1 ctrl", v, 32'h0);
      rd(5, v);  chk("R1 prescale", v, 32'h1);
      rd(10, v); chk("R1 status", v, 32'h0);
      chk("R1 outputs", {28'h0, irq, cpu_rst, sys_rst, full_rst}, 32'h0);

      // R2 writes refused while locked
      bus_wr(0, 32'h1);
      bus_wr(1, 32'h5);
      bus_wr(5, 32'h3);
      rd(0, v); chk("R2 ctrl locked", v, 32'h0);
      rd(1, v); chk("R2 tmo locked", v, 32'd1000);
      rd(5, v); chk("R2 prescale locked", v, 32'h1);

      // R3 key handling
      bus_wr(9, 32'h1234);
      rd(10, v); chk("R3 wrong key", v[1], 1'b0);
      bus_wr(9, KEY);
      rd(10, v); chk("R3 unlock", v[1], 1'b1);

      // R4 R5 R6: P=2, timeouts 3,2,4,1; actions off,cpu,sys,full
      bus_wr(5, 32'h2);
      bus_wr(1, 32'd3);
      bus_wr(2, 32'd2);
      bus_wr(3, 32'd4);
      bus_wr(4, 32'd1);
      bus_wr(0, 32'h1 | (32'd2 << 5) | (32'd3 << 8) | (32'd4 << 11));
      n = wr_last;
      expect_ev(1, n + 10); expect_ev(2, n + 18); expect_ev(3, n + 20);
      expect_ev(1, n + 30); expect_ev(2, n + 38); expect_ev(3, n + 40);
      rd(0, v); chk("R9 run readback", v[0], 1'b1);
      wait_until(n + 7);
      rd(10, v); chk("R5 stage 1 reached", 32'(v[3:2]), 32'd1);
      wait_until(n + 41);
      bus_wr(0, 32'h0);
      rd(0, v);  chk("R9 run cleared", v[0], 1'b0);
      rd(10, v); chk("R9 stage back to 0", 32'(v[3:2]), 32'd0);
      repeat (30) @(posedge clk);
      chk("R6 all expected pulses seen", 32'(expq.size()), 32'd0);
      chk("R7 no full pulse without option", 32'(nf_full), 32'd0);
      chk("R7 cpu pulses match without option", 32'(nf_cpu), 32'd2);

      // R4 prescale 0, R8 feed, R2 locked feed, R7 code 5 off
      bus_wr(5, 32'h0);
      bus_wr(1, 32'd4);
      bus_wr(0, 32'h1 | (32'd2 << 2) | (32'd5 << 11));
      n = wr_last;
      expect_ev(1, n + 4);
      wait_until(n + 8);
      bus_wr(6, 32'h1);
      f = wr_last;
      expect_ev(1, f + 4); expect_ev(1, f + 15);
      rd(10, v); chk("R8 feed to stage 0", 32'(v[3:2]), 32'd0);
      wait_until(f + 6);
      bus_wr(9, 32'h0);
      bus_wr(6, 32'h1);
      rd(10, v);
      chk("R3 relocked", v[1], 1'b0);
      chk("R2 locked feed ignored", 32'(v[3:2]), 32'd2);
      wait_until(f + 16);
      bus_wr(9, KEY);
      bus_wr(0, 32'h0);
      repeat (20) @(posedge clk);
      chk("R8 feed pulses seen", 32'(expq.size()), 32'd0);

      // R10 interrupt
      bus_wr(5, 32'h1);
      bus_wr(0, 32'h1 | 32'h2 | (32'd1 << 2));
      n = wr_last;
      wait_until(n + 6);
      rd(10, v); chk("R10 pending sticky", v[0], 1'b1);
      chk("R10 irq gated by enable", irq, 1'b0);
      bus_wr(7, 32'h1);
      w = wr_last;
      expect_ev(0, w);
      @(negedge clk); #1;
      chk("R10 irq raised", irq, 1'b1);
      bus_wr(8, 32'h1);
      @(negedge clk); #1;
      chk("R10 irq cleared", irq, 1'b0);
      rd(10, v); chk("R10 pending cleared", v[0], 1'b0);
      bus_wr(0, 32'h0);
      rd(7, v); chk("R10 int enable readback", v, 32'h1);
      repeat (10) @(posedge clk);
      chk("R10 irq event seen", 32'(expq.size()), 32'd0);

      summary();
      $finish;
   end
endmodule